// File: doc/BRIEF.md
# Load-Pair Execution Sequencer

This block carries out one integer load-pair operation. The caller presents a 32-bit instruction word together with the value of the general register named by the base field and the current stack-pointer value. The block decodes the element size and the addressing mode, forms the scaled signed offset and picks the access address. It then fetches both elements through a valid/ready request channel and a response channel. The fetch is either two element-sized reads, one after the other, or a single double-width read when `pair_fetch` is set. In one closing cycle it presents both register writes and any base writeback.

A state machine drives the sequence. Its states are ST_IDLE, ST_REQ_A, ST_RSP_A, ST_REQ_B, ST_RSP_B, ST_COMMIT and ST_FAULT, and its transitions are:
- ST_IDLE to ST_REQ_A on a legal start.
- ST_IDLE to ST_FAULT on a legal start with a misaligned stack-pointer base.
- ST_REQ_A to ST_RSP_A on the request handshake.
- ST_RSP_A to ST_REQ_B on a response when two reads are used.
- ST_RSP_A to ST_COMMIT on a response when one double-width read is used.
- ST_REQ_B to ST_RSP_B on the handshake.
- ST_RSP_B to ST_COMMIT on the response.
- ST_COMMIT and ST_FAULT both return to ST_IDLE after one cycle.

Top module: `pair_load_seq`

## Requirements
- R1: A start is taken only in the idle state and only when the encoding is legal: bits 31:30 equal 00 or 10, bits 29:27 equal 101, bit 26 equals 0, bit 22 equals 1, and bits 25:23 equal 001, 011 or 010. Any other start is ignored: `idle` stays high and no request is issued.
- R2: The offset is imm7 (bits 21:15), sign-extended and multiplied by 4 when bits 31:30 are 00 (word elements) or by 8 when they are 10 (doubleword elements).
- R3: Mode 010 (signed offset) reads at base plus offset and performs no base writeback.
- R4: Mode 011 (pre-index) reads at base plus offset and writes that same address back to the base.
- R5: Mode 001 (post-index) reads at the unmodified base and writes base plus offset back to the base.
- R6: With two reads, the second request address equals the first plus 4 (word) or plus 8 (doubleword). `req_size` gives log2 of the byte count: 2 means 4 bytes, 3 means 8 bytes and 4 means 16 bytes.
- R7: A base field (bits 9:5) of 31 selects `sp_val` as the base. Its writeback raises `wb_to_sp`. Other base fields use `base_val`, and their writeback goes to `wb_idx` with `wb_to_sp` low.
- R8: With the stack pointer as base and its low 4 bits non-zero, the block issues no request and no register write or writeback. It pulses `done` and `fault_align` together.
- R9: Word elements are zero-extended to 64 bits. The response element occupies the low bits of `rsp_data`.
- R10: The second read is requested only after the first response has arrived. While `req_ready` is low, the request and its address and size are held.
- R11: With `pair_fetch` set, one request of twice the element size is made. In little-endian mode (`big_endian` = 0) the low half goes to the first target (bits 4:0) and the high half to the second target (bits 14:10). In big-endian mode the halves are swapped.
- R12: `done` is a one-cycle pulse. Both register writes and any writeback are asserted only in that cycle.
- R13: `unpred` is raised with `done` when the two targets are equal, or when writeback is enabled and a target equals a general-register base. With equal targets only port 1 writes, carrying the second element. With a target equal to the base, the writeback is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch the operation in `instr` |
| instr | input | 32 | Instruction word |
| base_val | input | 64 | Value of the general register named by the base field |
| sp_val | input | 64 | Stack-pointer value |
| big_endian | input | 1 | Half ordering for a double-width read |
| pair_fetch | input | 1 | Fetch both elements with one double-width read |
| idle | output | 1 | Ready to accept a start |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory read request accepted |
| req_addr | output | 64 | Read address |
| req_size | output | 3 | log2 of the read byte count |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 128 | Read data, element 0 in the low bits |
| wr0_en | output | 1 | Write enable for the first target |
| wr0_idx | output | 5 | First target index |
| wr0_data | output | 64 | First target value |
| wr1_en | output | 1 | Write enable for the second target |
| wr1_idx | output | 5 | Second target index |
| wr1_data | output | 64 | Second target value |
| wb_en | output | 1 | Base writeback enable |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Base register index for writeback |
| wb_data | output | 64 | Written-back address |
| done | output | 1 | Operation finished |
| fault_align | output | 1 | Misaligned stack-pointer fault |
| unpred | output | 1 | Register-overlap case was resolved by rule |

## Verification
The hardest case to reach is ordering under stall. A faulty sequencer only shows itself when the second request would overlap a response that is still outstanding. Normal back-to-back timing hides this. The bench therefore delays its responses by several cycles and flags any handshake made while one is pending. A separate scenario holds `req_ready` low across several cycles to check that the first request stays still. Overlap cases are reached by encoding equal target fields, and a target equal to the base in pre-index mode.

// File: rtl/pls_pkg.sv
package pls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_A,
        ST_RSP_A,
        ST_REQ_B,
        ST_RSP_B,
        ST_COMMIT,
        ST_FAULT
    } pls_state_e;

    typedef enum logic [1:0] {
        AM_POST,
        AM_PRE,
        AM_OFFSET,
        AM_NONE
    } pls_amode_e;

    localparam logic [2:0] ENC_POST   = 3'b001;
    localparam logic [2:0] ENC_PRE    = 3'b011;
    localparam logic [2:0] ENC_OFFSET = 3'b010;
    localparam logic [2:0] ENC_CLASS  = 3'b101;
    localparam logic [1:0] ENC_WORD   = 2'b00;
    localparam logic [1:0] ENC_DWORD  = 2'b10;

endpackage

// File: rtl/pls_decode.sv
module pls_decode
    import pls_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 7,
    parameter int IDX_W = 5
) (
    input  logic [31:0]      instr,
    output logic             legal,
    output logic             dword,
    output pls_amode_e       mode,
    output logic [IDX_W-1:0] rt,
    output logic [IDX_W-1:0] rt2,
    output logic [IDX_W-1:0] rn,
    output logic [XLEN-1:0]  offset
);
    localparam int IMM_LSB = 15;
    localparam int RT2_LSB = 10;
    localparam int RN_LSB  = 5;

    logic [1:0]       size_f;
    logic [2:0]       mode_f;
    logic [IMM_W-1:0] imm_f;
    logic [XLEN-1:0]  imm_sext;
    logic             size_ok;
    logic             class_ok;

    always_comb begin
        size_f   = instr[31:30];
        mode_f   = instr[25:23];
        imm_f    = instr[IMM_LSB +: IMM_W];
        rt       = instr[0 +: IDX_W];
        rt2      = instr[RT2_LSB +: IDX_W];
        rn       = instr[RN_LSB +: IDX_W];
        dword    = (size_f == ENC_DWORD);
        size_ok  = (size_f == ENC_WORD) || (size_f == ENC_DWORD);
        class_ok = (instr[29:27] == ENC_CLASS) && !instr[26] && instr[22];
        unique case (mode_f)
            ENC_POST:   mode = AM_POST;
            ENC_PRE:    mode = AM_PRE;
            ENC_OFFSET: mode = AM_OFFSET;
            default:    mode = AM_NONE;
        endcase
        legal    = size_ok && class_ok && (mode != AM_NONE);
        imm_sext = {{(XLEN-IMM_W){imm_f[IMM_W-1]}}, imm_f};
        offset   = dword ? (imm_sext << 3) : (imm_sext << 2);
    end
endmodule

// File: rtl/pls_agen.sv
module pls_agen
    import pls_pkg::*;
#(
    parameter int XLEN          = 64,
    parameter int IDX_W         = 5,
    parameter int SP_ALIGN_LOG2 = 4
) (
    input  logic [XLEN-1:0]  base_val,
    input  logic [XLEN-1:0]  sp_val,
    input  logic [IDX_W-1:0] rn,
    input  logic [XLEN-1:0]  offset,
    input  pls_amode_e       mode,
    output logic [XLEN-1:0]  acc_addr,
    output logic [XLEN-1:0]  wb_addr,
    output logic             wb_req,
    output logic             use_sp,
    output logic             sp_misaligned
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] sum;

    always_comb begin
        use_sp        = (rn == {IDX_W{1'b1}});
        base          = use_sp ? sp_val : base_val;
        sum           = base + offset;
        acc_addr      = (mode == AM_POST) ? base : sum;
        wb_addr       = sum;
        wb_req        = (mode == AM_POST) || (mode == AM_PRE);
        sp_misaligned = use_sp && (|base[SP_ALIGN_LOG2-1:0]);
    end
endmodule

// File: rtl/pls_unpack.sv
module pls_unpack #(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0] raw,
    input  logic              dword,
    input  logic              big_endian,
    output logic [XLEN-1:0]   single,
    output logic [XLEN-1:0]   first,
    output logic [XLEN-1:0]   second
);
    localparam int HALF_W = XLEN / 2;

    logic [XLEN-1:0] half_v [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half_v[h] = dword ? raw[h*XLEN +: XLEN]
                                 : {{HALF_W{1'b0}}, raw[h*HALF_W +: HALF_W]};
    end

    assign single = half_v[0];
    assign first  = big_endian ? half_v[1] : half_v[0];
    assign second = big_endian ? half_v[0] : half_v[1];
endmodule

// File: rtl/pair_load_seq.sv
module pair_load_seq
    import pls_pkg::*;
#(
    parameter int XLEN          = 64,
    parameter int IMM_W         = 7,
    parameter int IDX_W         = 5,
    parameter int SP_ALIGN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   sp_val,
    input  logic              big_endian,
    input  logic              pair_fetch,
    output logic              idle,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [XLEN-1:0]   req_addr,
    output logic [2:0]        req_size,
    input  logic              rsp_valid,
    input  logic [2*XLEN-1:0] rsp_data,
    output logic              wr0_en,
    output logic [IDX_W-1:0]  wr0_idx,
    output logic [XLEN-1:0]   wr0_data,
    output logic              wr1_en,
    output logic [IDX_W-1:0]  wr1_idx,
    output logic [XLEN-1:0]   wr1_data,
    output logic              wb_en,
    output logic              wb_to_sp,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              done,
    output logic              fault_align,
    output logic              unpred
);
    localparam int HALF_W     = XLEN / 2;
    localparam int WORD_BYTES = HALF_W / 8;
    localparam int DW_BYTES   = XLEN / 8;
    localparam logic [2:0] WORD_LOG2 = 3'($clog2(WORD_BYTES));
    localparam logic [2:0] DW_LOG2   = 3'($clog2(DW_BYTES));

    // decode and address generation
    logic             d_legal, d_dword;
    pls_amode_e       d_mode;
    logic [IDX_W-1:0] d_rt, d_rt2, d_rn;
    logic [XLEN-1:0]  d_offset;
    logic [XLEN-1:0]  a_acc, a_wb;
    logic             a_wb_req, a_use_sp, a_sp_bad;

    pls_decode #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_decode (
        .instr  (instr),
        .legal  (d_legal),
        .dword  (d_dword),
        .mode   (d_mode),
        .rt     (d_rt),
        .rt2    (d_rt2),
        .rn     (d_rn),
        .offset (d_offset)
    );

    pls_agen #(.XLEN(XLEN), .IDX_W(IDX_W), .SP_ALIGN_LOG2(SP_ALIGN_LOG2)) u_agen (
        .base_val      (base_val),
        .sp_val        (sp_val),
        .rn            (d_rn),
        .offset        (d_offset),
        .mode          (d_mode),
        .acc_addr      (a_acc),
        .wb_addr       (a_wb),
        .wb_req        (a_wb_req),
        .use_sp        (a_use_sp),
        .sp_misaligned (a_sp_bad)
    );

    // latched operation context
    pls_state_e       state, state_nx;
    logic             dword_q, wide_q, be_q, use_sp_q, wb_req_q;
    logic [IDX_W-1:0] rt_q, rt2_q, rn_q;
    logic [XLEN-1:0]  addr_q, wbaddr_q, data0_q, data1_q;
    logic [XLEN-1:0]  u_single, u_first, u_second;
    logic             accept;
    logic             same_tgt, base_clash;

    pls_unpack #(.XLEN(XLEN)) u_unpack (
        .raw        (rsp_data),
        .dword      (dword_q),
        .big_endian (be_q),
        .single     (u_single),
        .first      (u_first),
        .second     (u_second)
    );

    assign accept = (state == ST_IDLE) && start && d_legal;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = a_sp_bad ? ST_FAULT : ST_REQ_A;
            ST_REQ_A:  if (req_ready) state_nx = ST_RSP_A;
            ST_RSP_A:  if (rsp_valid) state_nx = wide_q ? ST_COMMIT : ST_REQ_B;
            ST_REQ_B:  if (req_ready) state_nx = ST_RSP_B;
            ST_RSP_B:  if (rsp_valid) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            ST_FAULT:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // context and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dword_q  <= 1'b0;
            wide_q   <= 1'b0;
            be_q     <= 1'b0;
            use_sp_q <= 1'b0;
            wb_req_q <= 1'b0;
            rt_q     <= '0;
            rt2_q    <= '0;
            rn_q     <= '0;
            addr_q   <= '0;
            wbaddr_q <= '0;
            data0_q  <= '0;
            data1_q  <= '0;
        end else begin
            if (accept) begin
                dword_q  <= d_dword;
                wide_q   <= pair_fetch;
                be_q     <= big_endian;
                use_sp_q <= a_use_sp;
                wb_req_q <= a_wb_req;
                rt_q     <= d_rt;
                rt2_q    <= d_rt2;
                rn_q     <= d_rn;
                addr_q   <= a_acc;
                wbaddr_q <= a_wb;
            end
            if (state == ST_RSP_A && rsp_valid) begin
                data0_q <= wide_q ? u_first : u_single;
                if (wide_q) data1_q <= u_second;
            end
            if (state == ST_RSP_B && rsp_valid) data1_q <= u_single;
        end
    end

    assign same_tgt   = (rt_q == rt2_q);
    assign base_clash = wb_req_q && !use_sp_q && ((rn_q == rt_q) || (rn_q == rt2_q));

    // outputs
    always_comb begin
        idle        = (state == ST_IDLE);
        req_valid   = 1'b0;
        req_addr    = addr_q;
        req_size    = dword_q ? DW_LOG2 : WORD_LOG2;
        wr0_en      = 1'b0;
        wr1_en      = 1'b0;
        wb_en       = 1'b0;
        wb_to_sp    = 1'b0;
        done        = 1'b0;
        fault_align = 1'b0;
        unpred      = 1'b0;
        wr0_idx     = rt_q;
        wr1_idx     = rt2_q;
        wr0_data    = data0_q;
        wr1_data    = data1_q;
        wb_idx      = rn_q;
        wb_data     = wbaddr_q;
        unique case (state)
            ST_REQ_A: begin
                req_valid = 1'b1;
                if (wide_q) req_size = dword_q ? DW_LOG2 + 3'd1 : WORD_LOG2 + 3'd1;
            end
            ST_REQ_B: begin
                req_valid = 1'b1;
                req_addr  = addr_q + (dword_q ? XLEN'(DW_BYTES) : XLEN'(WORD_BYTES));
            end
            ST_COMMIT: begin
                done     = 1'b1;
                wr0_en   = !same_tgt;
                wr1_en   = 1'b1;
                wb_en    = wb_req_q && !base_clash;
                wb_to_sp = wb_req_q && !base_clash && use_sp_q;
                unpred   = same_tgt || base_clash;
            end
            ST_FAULT: begin
                done        = 1'b1;
                fault_align = 1'b1;
            end
            default: ;
        endcase
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_size));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_align |-> !wr0_en && !wr1_en && !wb_en && !req_valid);

    // R7
    wb_gpr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en && !wb_to_sp |-> wb_idx != {IDX_W{1'b1}});

    // R9
    word_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr1_en && !dword_q |-> wr1_data[XLEN-1:HALF_W] == '0);

    // R13
    wb_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en && !wb_to_sp |-> (wb_idx != wr1_idx) && (!wr0_en || wb_idx != wr0_idx));

    // R12
    writes_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en || wr1_en || wb_en) |-> done);
endmodule

// File: tb/pair_load_seq_bench.sv
module pair_load_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  instr = '0;
    logic [63:0]  base_val = '0;
    logic [63:0]  sp_val = '0;
    logic         big_endian = 1'b0;
    logic         pair_fetch = 1'b0;
    logic         idle;
    logic         req_valid;
    logic         req_ready = 1'b1;
    logic [63:0]  req_addr;
    logic [2:0]   req_size;
    logic         rsp_valid = 1'b0;
    logic [127:0] rsp_data = '0;
    logic         wr0_en, wr1_en, wb_en, wb_to_sp, done, fault_align, unpred;
    logic [4:0]   wr0_idx, wr1_idx, wb_idx;
    logic [63:0]  wr0_data, wr1_data, wb_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pair_load_seq u_pair_load_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .base_val(base_val), .sp_val(sp_val), .big_endian(big_endian),
        .pair_fetch(pair_fetch), .idle(idle), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
        .wb_en(wb_en), .wb_to_sp(wb_to_sp), .wb_idx(wb_idx), .wb_data(wb_data),
        .done(done), .fault_align(fault_align), .unpred(unpred)
    );

    // memory model
    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] + (a[15:8] * 8'd17) + 8'h21;
    endfunction

    function automatic logic [127:0] mem_load(input logic [63:0] a, input int nbytes);
        logic [127:0] d = '0;
        for (int i = 0; i < nbytes; i++) d[i*8 +: 8] = mem_byte(a + 64'(i));
        return d;
    endfunction

    int          rsp_lat = 0;
    logic        log_clr = 1'b0;
    logic        pend = 1'b0;
    int          wait_cnt = 0;
    logic [127:0] pend_data = '0;
    int          req_n = 0;
    int          order_err = 0;
    logic [63:0] log_addr [4];
    logic [2:0]  log_size [4];

    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        if (log_clr) begin
            req_n     <= 0;
            order_err <= 0;
        end
        if (pend) begin
            if (wait_cnt == 0) begin
                rsp_valid <= 1'b1;
                rsp_data  <= pend_data;
                pend      <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
        if (req_valid && req_ready) begin
            if (pend || rsp_valid) order_err <= order_err + 1;
            pend      <= 1'b1;
            wait_cnt  <= rsp_lat;
            pend_data <= mem_load(req_addr, 1 << req_size);
            if (req_n < 4) begin
                log_addr[req_n] <= req_addr;
                log_size[req_n] <= req_size;
            end
            req_n <= req_n + 1;
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic dw, input logic [2:0] md,
                                        input logic [6:0] imm, input logic [4:0] t2,
                                        input logic [4:0] n, input logic [4:0] t);
        return {(dw ? 2'b10 : 2'b00), 3'b101, 1'b0, md, 1'b1, imm, t2, n, t};
    endfunction

    // captured at the done cycle
    logic        c_done, c_wr0, c_wr1, c_wb, c_sp, c_fault, c_unp;
    logic [4:0]  c_i0, c_i1, c_ib;
    logic [63:0] c_d0, c_d1, c_db;

    task automatic launch(input logic [31:0] ins, input logic [63:0] b, input logic [63:0] s,
                          input logic be, input logic pf, input int hold);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr    = 1'b0;
        instr      = ins;
        base_val   = b;
        sp_val     = s;
        big_endian = be;
        pair_fetch = pf;
        if (hold > 0) req_ready = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (hold > 0) begin
            logic [63:0] a0 = req_addr;
            repeat (hold) @(negedge clk);
            check("R10 request held while not ready", {req_valid, req_addr}, {1'b1, a0});
            req_ready = 1'b1;
        end
        c_done = 1'b0;
        for (int t = 0; t < 300 && !c_done; t++) begin
            if (done) begin
                c_done = 1'b1;
                c_wr0 = wr0_en; c_wr1 = wr1_en; c_wb = wb_en; c_sp = wb_to_sp;
                c_fault = fault_align; c_unp = unpred;
                c_i0 = wr0_idx; c_i1 = wr1_idx; c_ib = wb_idx;
                c_d0 = wr0_data; c_d1 = wr1_data; c_db = wb_data;
            end else begin
                @(negedge clk);
            end
        end
        check("R12 done reached", 128'(c_done), 128'(1));
        @(negedge clk);
        check("R12 done is one cycle", {done, wr0_en, wr1_en, wb_en, idle}, 5'b00001);
    endtask

    // full check of a regular two-element load
    task automatic run_regular(input string nm, input logic dw, input logic [2:0] md,
                               input logic [6:0] imm, input logic [4:0] t2, input logic [4:0] n,
                               input logic [4:0] t, input logic [63:0] b, input logic [63:0] s,
                               input logic be, input logic pf);
        int          eb  = dw ? 8 : 4;
        logic [63:0] off = 64'(signed'({{57{imm[6]}}, imm})) * 64'(eb);
        logic [63:0] bs  = (n == 5'd31) ? s : b;
        logic [63:0] acc = (md == 3'b001) ? bs : bs + off;
        logic        wbr = (md != 3'b010);
        logic [127:0] raw;
        logic [63:0] e0, e1;
        if (pf) begin
            raw = mem_load(acc, 2 * eb);
            e0 = dw ? raw[63:0] : {32'b0, raw[31:0]};
            e1 = dw ? raw[127:64] : {32'b0, raw[63:32]};
            if (be) begin
                logic [63:0] tmp = e0;
                e0 = e1;
                e1 = tmp;
            end
        end else begin
            e0 = mem_load(acc, eb)[63:0];
            e1 = mem_load(acc + 64'(eb), eb)[63:0];
        end
        launch(enc(dw, md, imm, t2, n, t), b, s, be, pf, 0);
        $display("scenario %s", nm);
        if (pf) begin
            check("R11 single request", 128'(req_n), 128'(1));
            check("R11 double-width size", {log_addr[0], log_size[0]}, {acc, dw ? 3'd4 : 3'd3});
        end else begin
            check("R6 two requests", 128'(req_n), 128'(2));
            check("R2 R3 R4 R5 first address", {log_addr[0], log_size[0]}, {acc, dw ? 3'd3 : 3'd2});
            check("R6 second address", {log_addr[1], log_size[1]}, {acc + 64'(eb), dw ? 3'd3 : 3'd2});
        end
        check("R9 R11 first target", {c_wr0, c_i0, c_d0}, {1'b1, t, e0});
        check("R9 R11 second target", {c_wr1, c_i1, c_d1}, {1'b1, t2, e1});
        check("R3 R4 R5 writeback enable", 128'(c_wb), 128'(wbr));
        if (wbr) check("R4 R5 R7 writeback target", {c_sp, c_ib, c_db},
                       {n == 5'd31, n, bs + off});
        check("R13 no overlap flag", {c_unp, c_fault}, 2'b00);
        check("R10 no overlapping request", 128'(order_err), 128'(0));
    endtask

    task automatic t_reset();
        check("R12 reset outputs", {idle, req_valid, done, wr0_en, wr1_en, wb_en, fault_align},
              7'b1000000);
    endtask

    task automatic t_illegal();
        logic [31:0] bad [3];
        bad[0] = enc(1'b0, 3'b010, 7'd2, 5'd2, 5'd1, 5'd3) & ~32'h0040_0000;
        bad[1] = enc(1'b0, 3'b010, 7'd2, 5'd2, 5'd1, 5'd3) | 32'h4000_0000;
        bad[2] = enc(1'b1, 3'b000, 7'd2, 5'd2, 5'd1, 5'd3);
        for (int k = 0; k < 3; k++) begin
            logic seen = 1'b0;
            log_clr = 1'b1;
            @(negedge clk);
            log_clr = 1'b0;
            instr = bad[k];
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int t = 0; t < 6; t++) begin
                if (!idle || req_valid || done) seen = 1'b1;
                @(negedge clk);
            end
            check("R1 illegal start ignored", {seen, 32'(req_n)}, {1'b0, 32'd0});
        end
    endtask

    task automatic t_sp_fault();
        launch(enc(1'b1, 3'b011, 7'd4, 5'd2, 5'd31, 5'd1), 64'h0, 64'h0000_0000_0000_1008,
               1'b0, 1'b0, 0);
        check("R8 fault pulse without writes", {c_fault, c_wr0, c_wr1, c_wb}, 4'b1000);
        check("R8 no memory request", 128'(req_n), 128'(0));
    endtask

    task automatic t_backpressure();
        logic [63:0] b = 64'h0000_0000_0002_0000;
        rsp_lat = 3;
        launch(enc(1'b1, 3'b010, 7'd1, 5'd9, 5'd4, 5'd8), b, 64'h0, 1'b0, 1'b0, 4);
        check("R10 second request after first response", 128'(order_err), 128'(0));
        check("R10 both elements", {c_d0, c_d1},
              {mem_load(b + 64'd8, 8)[63:0], mem_load(b + 64'd16, 8)[63:0]});
        rsp_lat = 0;
    endtask

    task automatic t_overlap();
        logic [63:0] b = 64'h0000_0000_0000_4000;
        launch(enc(1'b0, 3'b010, 7'd0, 5'd5, 5'd2, 5'd5), b, 64'h0, 1'b0, 1'b0, 0);
        check("R13 equal targets", {c_unp, c_wr0, c_wr1, c_i1, c_d1},
              {1'b1, 1'b0, 1'b1, 5'd5, {32'b0, mem_load(b + 64'd4, 4)[31:0]}});
        launch(enc(1'b1, 3'b011, 7'd2, 5'd7, 5'd7, 5'd3), b, 64'h0, 1'b0, 1'b0, 0);
        check("R13 base overlap drops writeback", {c_unp, c_wr0, c_wr1, c_wb}, 4'b1110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_illegal();
        run_regular("word offset", 1'b0, 3'b010, 7'd3, 5'd4, 5'd1, 5'd3,
                    64'h0000_0000_0000_1000, 64'h0, 1'b1, 1'b0);
        run_regular("dword pre negative", 1'b1, 3'b011, 7'h7E, 5'd11, 5'd6, 5'd10,
                    64'h0000_0000_0000_2040, 64'h0, 1'b0, 1'b0);
        run_regular("word post", 1'b0, 3'b001, 7'd4, 5'd13, 5'd2, 5'd12,
                    64'h0000_0000_0000_3000, 64'h0, 1'b0, 1'b0);
        run_regular("sp pre", 1'b1, 3'b011, 7'h7C, 5'd15, 5'd31, 5'd14,
                    64'hDEAD, 64'h0000_0000_0000_5100, 1'b0, 1'b0);
        t_sp_fault();
        run_regular("wide dword le", 1'b1, 3'b010, 7'd2, 5'd17, 5'd3, 5'd16,
                    64'h0000_0000_0000_6000, 64'h0, 1'b0, 1'b1);
        run_regular("wide word be", 1'b0, 3'b001, 7'd1, 5'd19, 5'd3, 5'd18,
                    64'h0000_0000_0000_7004, 64'h0, 1'b1, 1'b1);
        t_backpressure();
        t_overlap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end
endmodule